// File: doc/BRIEF.md
# Coherence-Aware Victim Way Selector

This block chooses which way of one cache set should be evicted when a miss needs a frame. Each way's valid bit and two-bit coherence state arrive as flat vectors. The block keeps an LRU age for every way of the set in its own registers. Candidates are ranked before age is considered. A free way (not valid, or in the invalid state) always wins, lowest index first. After that a shared line goes before an exclusive one, and any clean line goes before a modified one. Age only separates ways of the same rank: the oldest goes first, and the lowest index settles any remaining tie. A dirty flag tells the miss handler that the chosen victim must be written back.

The selection is purely combinational from the registered ages and the current state inputs. A request is accepted in every cycle: `victim_valid` simply mirrors `req_valid` in the same cycle, and there is no back-pressure, so no ready signal exists. Hits and fills are reported on a separate plain strobe with a way index. The age change appears after the next clock edge. The `USE_MSI` parameter selects the three-state protocol. In that mode the exclusive encoding is never expected, and if it appears it is ranked as shared. Setting `WAYS` to 1 gives the direct-mapped case.

Top module: `victim_select`

## Requirements
- R1: A way whose valid bit is low or whose state is 2'b00 (invalid) is always chosen ahead of any occupied way, and among such free ways the lowest index is chosen.
- R2: With no free way, a valid way in state 2'b01 (shared) is chosen ahead of a way in state 2'b10 (exclusive), whatever their ages.
- R3: With no free way, any clean way (state 2'b01 or 2'b10) is chosen ahead of a way in state 2'b11 (modified), whatever their ages.
- R4: Among occupied ways of equal rank, the way with the largest age is chosen, and the lowest index breaks any tie that remains.
- R5: `victim_dirty` is high exactly when the chosen way is valid and in state 2'b11.
- R6: A cycle with `touch_valid` high sets the age of `touch_way` to 0 at the next edge. Every other way whose age was below the touched way's old age increments by one, saturating at WAYS-1. All remaining ages hold.
- R7: After reset, the age of way i equals i. Ages are read on `ages_o` with way i in bits [i*AW +: AW].
- R8: With `USE_MSI` set, state 2'b10 is ranked exactly like shared (2'b01).
- R9: With WAYS = 1 the victim is always way 0, its age stays 0, and `victim_dirty` follows that way's modified state.
- R10: `victim_valid` equals `req_valid` in the same cycle. The victim outputs are combinational from the current inputs and the registered ages, and no request is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Victim request strobe |
| way_valid | input | WAYS | Per-way valid bits |
| way_state | input | 2*WAYS | Per-way coherence state; way i in bits [2i+1:2i]; 00 invalid, 01 shared, 10 exclusive, 11 modified |
| touch_valid | input | 1 | Hit or fill strobe |
| touch_way | input | IW | Way that was hit or filled |
| victim_valid | output | 1 | Victim outputs are meaningful this cycle |
| victim_way | output | IW | Chosen way |
| victim_dirty | output | 1 | Chosen way needs a write-back |
| ages_o | output | WAYS*AW | Current per-way LRU ages |

## Verification
The assertions assume that `touch_way` always names an existing way and that state inputs are settled before the sampling edge. They also assume that, in the three-state mode, a stray exclusive code only needs to be ranked, not flagged. The bench changes inputs only on the falling edge. With four ways, every `touch_way` value is in range, so random touches cannot leave that space. Random touch sequences keep the ages a permutation, as they are from reset. Directed cases make the ranking disagree with pure age order, so that an age-only selector would show up at the ports.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

  typedef enum logic [1:0] {
    COH_INV = 2'b00,
    COH_SHD = 2'b01,
    COH_EXC = 2'b10,
    COH_MOD = 2'b11
  } coh_e;

  // Eviction rank, lower goes first
  typedef enum logic [1:0] {
    RK_FREE   = 2'd0,
    RK_SHARED = 2'd1,
    RK_EXCL   = 2'd2,
    RK_DIRTY  = 2'd3
  } rank_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/victim_rank.sv
// Builds a per-way compare key: {rank, inverted age}; free ways get key 0
module victim_rank
  import vsel_pkg::*;
#(
  parameter int WAYS     = 4,
  parameter int AW       = 2,
  parameter bit USE_MSI  = 1'b0,
  localparam int KW      = 2 + AW
) (
  input  logic [WAYS-1:0]    way_valid,
  input  logic [2*WAYS-1:0]  way_state,
  input  logic [WAYS*AW-1:0] ages,
  output logic [WAYS*KW-1:0] keys
);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    coh_e  st;
    rank_e rk;
    logic [AW-1:0] age;

    assign st  = coh_e'(way_state[2*g +: 2]);
    assign age = ages[g*AW +: AW];

    always_comb begin
      if (!way_valid[g]) begin
        rk = RK_FREE;
      end else begin
        case (st)
          COH_INV: rk = RK_FREE;
          COH_SHD: rk = RK_SHARED;
          COH_EXC: rk = USE_MSI ? RK_SHARED : RK_EXCL;
          COH_MOD: rk = RK_DIRTY;
          default: rk = RK_DIRTY;
        endcase
      end
    end

    // Free ways ignore age so the lowest index wins among them
    assign keys[g*KW +: KW] = (rk == RK_FREE) ? '0 : {rk, ~age};
  end

endmodule

// File: rtl/victim_pick.sv
// Linear minimum search; strict compare keeps the lowest index on ties
module victim_pick
  import vsel_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int AW   = 2,
  parameter int IW   = 2,
  localparam int KW  = 2 + AW
) (
  input  logic [WAYS*KW-1:0] keys,
  output logic [IW-1:0]      best_idx,
  output rank_e              best_rank
);

  logic [KW-1:0] best_key;

  always_comb begin
    best_idx = '0;
    best_key = keys[KW-1:0];
    for (int i = 1; i < WAYS; i++) begin
      if (keys[i*KW +: KW] < best_key) begin
        best_key = keys[i*KW +: KW];
        best_idx = IW'(i);
      end
    end
  end

  assign best_rank = rank_e'(best_key[KW-1 -: 2]);

endmodule

// File: rtl/lru_ages.sv
// Per-way LRU age registers for one set
module lru_ages #(
  parameter int WAYS = 4,
  parameter int AW   = 2,
  parameter int IW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_valid,
  input  logic [IW-1:0]      touch_way,
  output logic [WAYS*AW-1:0] ages_o
);

  localparam logic [AW-1:0] AGE_MAX = AW'(WAYS - 1);

  logic [AW-1:0] age_q [WAYS];
  logic [AW-1:0] old_age;

  always_comb begin
    old_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (touch_way == IW'(i)) old_age = age_q[i];
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_q[g] <= AW'(g);
      end else if (touch_valid) begin
        if (touch_way == IW'(g)) begin
          age_q[g] <= '0;
        end else if ((age_q[g] < old_age) && (age_q[g] != AGE_MAX)) begin
          age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end

    assign ages_o[g*AW +: AW] = age_q[g];

    // R6: touched way becomes most recent
    a_r6_touch_zero: assert property (@(posedge clk) disable iff (!rst_n)
      touch_valid && (touch_way == IW'(g)) |=> age_q[g] == '0);

    // R6: younger ways age by one
    a_r6_younger_inc: assert property (@(posedge clk) disable iff (!rst_n)
      touch_valid && (touch_way != IW'(g)) && (age_q[g] < old_age) && (age_q[g] != AGE_MAX)
      |=> age_q[g] == $past(age_q[g]) + 1'b1);

    // R6: older ways hold
    a_r6_older_hold: assert property (@(posedge clk) disable iff (!rst_n)
      touch_valid && (touch_way != IW'(g)) && (age_q[g] > old_age) |=> $stable(age_q[g]));

    // R6: no touch, no change
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !touch_valid |=> $stable(age_q[g]));
  end

endmodule

// File: rtl/victim_select.sv
module victim_select
  import vsel_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter bit USE_MSI = 1'b0,
  localparam int AW     = idx_bits(WAYS),
  localparam int IW     = idx_bits(WAYS),
  localparam int KW     = 2 + AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [WAYS-1:0]    way_valid,
  input  logic [2*WAYS-1:0]  way_state,
  input  logic               touch_valid,
  input  logic [IW-1:0]      touch_way,
  output logic               victim_valid,
  output logic [IW-1:0]      victim_way,
  output logic               victim_dirty,
  output logic [WAYS*AW-1:0] ages_o
);

  logic [WAYS*KW-1:0] keys;
  rank_e              best_rank;

  lru_ages #(.WAYS(WAYS), .AW(AW), .IW(IW)) u_ages (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_valid (touch_valid),
    .touch_way   (touch_way),
    .ages_o      (ages_o)
  );

  victim_rank #(.WAYS(WAYS), .AW(AW), .USE_MSI(USE_MSI)) u_rank (
    .way_valid (way_valid),
    .way_state (way_state),
    .ages      (ages_o),
    .keys      (keys)
  );

  victim_pick #(.WAYS(WAYS), .AW(AW), .IW(IW)) u_pick (
    .keys      (keys),
    .best_idx  (victim_way),
    .best_rank (best_rank)
  );

  assign victim_valid = req_valid;
  assign victim_dirty = (best_rank == RK_DIRTY);

  // Checker-side view of the raw inputs
  logic [WAYS-1:0] free_way, clean_way, low_mask;
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      free_way[i]  = !way_valid[i] || (way_state[2*i +: 2] == 2'b00);
      clean_way[i] = way_valid[i] && ((way_state[2*i +: 2] == 2'b01) ||
                                      (way_state[2*i +: 2] == 2'b10));
    end
    low_mask = (WAYS'(1) << victim_way) - WAYS'(1);
  end

  // R1: a free way wins when one exists
  a_r1_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (|free_way) |-> free_way[victim_way]);

  // R1: no lower-indexed free way is skipped
  a_r1_lowest_free: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (free_way & low_mask) == '0);

  // R3: a clean candidate beats every modified one
  a_r3_clean_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(|free_way) && (|clean_way) |-> !victim_dirty);

  // R5: dirty flag matches the chosen way's state
  a_r5_dirty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> victim_dirty ==
      (way_valid[victim_way] && (way_state[victim_way*2 +: 2] == 2'b11)));

endmodule

// File: tb/victim_select_tb.sv
module victim_select_tb;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           req_valid = 1'b0;
  logic [W-1:0]   way_valid = '0;
  logic [2*W-1:0] way_state = '0;
  logic           touch_valid = 1'b0;
  logic [1:0]     touch_way = '0;

  logic       vv_a, vd_a, vv_m, vd_m, vv_d, vd_d;
  logic [1:0] vw_a, vw_m;
  logic [0:0] vw_d;
  logic [7:0] ages_a, ages_m;
  logic [0:0] ages_d;

  victim_select #(.WAYS(W), .USE_MSI(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .way_valid(way_valid),
    .way_state(way_state), .touch_valid(touch_valid), .touch_way(touch_way),
    .victim_valid(vv_a), .victim_way(vw_a), .victim_dirty(vd_a), .ages_o(ages_a));

  victim_select #(.WAYS(W), .USE_MSI(1'b1)) u_msi (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .way_valid(way_valid),
    .way_state(way_state), .touch_valid(touch_valid), .touch_way(touch_way),
    .victim_valid(vv_m), .victim_way(vw_m), .victim_dirty(vd_m), .ages_o(ages_m));

  victim_select #(.WAYS(1), .USE_MSI(1'b0)) u_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .way_valid(way_valid[0:0]),
    .way_state(way_state[1:0]), .touch_valid(touch_valid), .touch_way(1'b0),
    .victim_valid(vv_d), .victim_way(vw_d), .victim_dirty(vd_d), .ages_o(ages_d));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int m_age [W];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void ref_pick(input logic [W-1:0] v, input logic [2*W-1:0] st,
                                   input bit msi, output int idx, output bit dirty);
    int best = 1000;
    int cls_best = 0;
    idx = 0;
    for (int i = 0; i < W; i++) begin
      int cls;
      int key;
      logic [1:0] s = st[2*i +: 2];
      if (!v[i] || s == 2'b00) cls = 0;
      else if (s == 2'b01)     cls = 1;
      else if (s == 2'b10)     cls = msi ? 1 : 2;
      else                     cls = 3;
      key = (cls == 0) ? 0 : cls * 16 + (15 - m_age[i]);
      if (key < best) begin
        best = key;
        idx = i;
        cls_best = cls;
      end
    end
    dirty = (cls_best == 3);
  endfunction

  task automatic step(input logic [W-1:0] v, input logic [2*W-1:0] st, input logic rq,
                      input logic tv, input logic [1:0] tw, input string rtag);
    int ei, mi;
    bit ed, md;
    @(negedge clk);
    way_valid = v; way_state = st; req_valid = rq; touch_valid = tv; touch_way = tw;
    #1;
    ref_pick(v, st, 1'b0, ei, ed);
    ref_pick(v, st, 1'b1, mi, md);
    check(rtag, "victim_way", int'(vw_a), ei);
    check("R5", "victim_dirty", int'(vd_a), int'(ed));
    check("R8", "msi victim_way", int'(vw_m), mi);
    check("R10", "victim_valid", int'(vv_a), int'(rq));
    check("R9", "dm victim_way", int'(vw_d), 0);
    check("R9", "dm victim_dirty", int'(vd_d), int'(v[0] && st[1:0] == 2'b11));
    for (int i = 0; i < W; i++)
      check("R6", "age", int'(ages_a[2*i +: 2]), m_age[i]);
    @(posedge clk);
    #1;
    if (tv) begin
      int old = m_age[tw];
      for (int i = 0; i < W; i++) begin
        if (i == int'(tw)) m_age[i] = 0;
        else if (m_age[i] < old && m_age[i] < W - 1) m_age[i] = m_age[i] + 1;
      end
    end
  endtask

  initial begin
    #(30000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    for (int i = 0; i < W; i++) m_age[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7 reset ages
    for (int i = 0; i < W; i++) check("R7", "reset age", int'(ages_a[2*i +: 2]), i);
    check("R9", "dm reset age", int'(ages_d), 0);

    // R1: all free -> way 0
    step(4'b0000, 8'h00, 1'b1, 1'b0, 2'd0, "R1");
    check("R1", "all free", int'(vw_a), 0);
    // R1: way 2 valid but state invalid, rest modified
    step(4'b1111, 8'b11_00_11_11, 1'b1, 1'b0, 2'd0, "R1");
    check("R1", "invalid state", int'(vw_a), 2);
    // R2: shared way1 (age1) beats exclusive way3 (age3)
    step(4'b1111, 8'b10_11_01_11, 1'b1, 1'b0, 2'd0, "R2");
    check("R2", "shared first", int'(vw_a), 1);
    // R8: same pattern under MSI ranks way3 as shared, older wins
    check("R8", "msi exclusive as shared", int'(vw_m), 3);
    // R3: exclusive way0 (age0) beats modified way3 (age3)
    step(4'b1111, 8'b11_11_11_10, 1'b1, 1'b0, 2'd0, "R3");
    check("R3", "clean first", int'(vw_a), 0);
    check("R5", "clean not dirty", int'(vd_a), 0);
    // R4/R5: all modified -> oldest, dirty
    step(4'b1111, 8'hFF, 1'b1, 1'b0, 2'd0, "R4");
    check("R4", "oldest", int'(vw_a), 3);
    check("R5", "dirty", int'(vd_a), 1);
    // R6: touch oldest way, then observe ages
    step(4'b1111, 8'hFF, 1'b0, 1'b1, 2'd3, "R4");
    step(4'b1111, 8'hFF, 1'b1, 1'b0, 2'd0, "R4");
    check("R6", "touched age", int'(ages_a[7:6]), 0);
    check("R4", "new oldest", int'(vw_a), 2);
    check("R9", "dm age stays", int'(ages_d), 0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0]   v  = W'($urandom);
      logic [2*W-1:0] st = (2*W)'($urandom);
      if ($urandom_range(0, 3) != 0) v = '1;
      step(v, st, 1'($urandom), 1'($urandom), 2'($urandom), "R4");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule